// File: doc/BRIEF.md
# Receive Frame Filter

This block sits behind the logic that drains a radio's receive FIFO and sees each received frame as a stream of bytes. The first byte of every frame is flagged by a start-of-frame marker and holds the frame length. The block then reads the source address, the destination address, a 32-bit payload and two trailing check bytes. A frame is forwarded to a downstream FIFO only if all of these hold: it has the expected length, it comes from a legal sender, it is addressed to this node or to everyone, and the radio reported a good CRC. Every other frame is discarded without any trace at the output.

The forwarded record is the sender's address together with the payload word, presented with a single-cycle push strobe. The downstream FIFO reports when it is full. A frame that qualifies while that FIFO is full is lost, and a saturating counter records the loss. A frame with a wrong length is still consumed byte for byte, as many bytes as its length field declares, so the parser stays aligned with the stream that follows.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset `out_push` is 0, `ovf_count` is 0, and `out_src` and `out_payload` are 0.
- R2: A frame is the length byte (marked by `in_sof`), then the source, the destination, the payload bytes most significant first, then two check bytes. It has length 8 (with the default of four payload bytes), a nonzero source, a destination equal to `node_addr`, and bit 7 of the last check byte set. With `out_full` low, such a frame raises `out_push` for exactly one cycle, in the cycle after the clock edge that takes the last check byte. In that cycle `out_src` holds the source and `out_payload` holds the payload.
- R3: A frame whose destination is 0xFF is accepted in the same way as a frame whose destination equals `node_addr`.
- R4: A frame whose destination is neither `node_addr` nor 0xFF produces no push.
- R5: A frame whose last check byte has bit 7 clear produces no push.
- R6: A frame whose length byte is not 8 produces no push. Exactly that many bytes after the length byte are consumed as part of it, and the next marked frame is parsed normally. A length of 0 ends the frame at once.
- R7: A frame whose source address is 0x00 produces no push.
- R8: When a frame that would be accepted completes while `out_full` is high, there is no push and `ovf_count` rises by one. The counter saturates at its maximum value.
- R9: A byte marked with `in_sof` always begins a new frame and abandons any frame still in progress. The abandoned frame produces no push.
- R10: Cycles with `in_valid` low carry no byte. A byte that is valid but unmarked, arriving when no frame is open, is ignored.
- R11: `out_src` and `out_payload` change only in a cycle where `out_push` is high, and keep their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 8 | This node's address |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_sof | input | 1 | The present byte is the length byte of a new frame |
| in_byte | input | 8 | Received byte |
| out_full | input | 1 | The downstream FIFO cannot take a record |
| out_push | output | 1 | One-cycle write strobe to the downstream FIFO |
| out_src | output | 8 | Source address of the forwarded frame |
| out_payload | output | 32 | Payload word of the forwarded frame |
| ovf_count | output | 8 | Saturating count of accepted frames lost to a full FIFO |

## Verification
Two things can land in the same cycle. The first is the push for a completed frame. The second is the length byte of the next frame, sent with no gap. The bench drives frames back to back and checks two results: the first record appears intact in the cycle that the second frame's length byte is being taken, and the second frame is then forwarded as well. A second collision comes from holding `out_full` high for exactly the cycle of the last check byte. That frame must raise the overflow count and not push, and the frame that follows with `out_full` low must push normally.

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int PAYLOAD_BYTES = 4,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 node_addr,
  input  logic                       in_valid,
  input  logic                       in_sof,
  input  logic [7:0]                 in_byte,
  input  logic                       out_full,
  output logic                       out_push,
  output logic [7:0]                 out_src,
  output logic [8*PAYLOAD_BYTES-1:0] out_payload,
  output logic [CNT_W-1:0]           ovf_count
);
  localparam int PW        = 8 * PAYLOAD_BYTES;
  localparam int FRAME_LEN = PAYLOAD_BYTES + 4;
  localparam logic [7:0] LEN_B     = 8'(FRAME_LEN);
  localparam logic [7:0] POS_SRC   = 8'd1;
  localparam logic [7:0] POS_DST   = 8'd2;
  localparam logic [7:0] POS_PAY0  = 8'd3;
  localparam logic [7:0] POS_PAYN  = 8'(PAYLOAD_BYTES + 2);
  localparam logic [7:0] BCAST     = 8'hFF;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic          open_q;
  logic [7:0]    len_q;
  logic [7:0]    pos_q;
  logic [7:0]    src_q;
  logic [7:0]    dst_q;
  logic [PW-1:0] pay_q;

  wire       start    = in_valid && in_sof;
  wire       body     = in_valid && !in_sof && open_q;
  wire [7:0] pos_nx   = pos_q + 8'd1;
  wire       last     = body && (pos_nx == len_q);
  wire       addr_hit = (dst_q == node_addr) || (dst_q == BCAST);
  wire       keep     = last && (len_q == LEN_B) && in_byte[7] && addr_hit && (src_q != 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      len_q       <= '0;
      pos_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      pay_q       <= '0;
      out_push    <= 1'b0;
      out_src     <= '0;
      out_payload <= '0;
      ovf_count   <= '0;
    end else begin
      out_push <= 1'b0;
      if (start) begin
        len_q  <= in_byte;
        pos_q  <= '0;
        open_q <= (in_byte != 8'h00);
      end else if (body) begin
        pos_q <= pos_nx;
        if (pos_nx == POS_SRC) src_q <= in_byte;
        if (pos_nx == POS_DST) dst_q <= in_byte;
        if (pos_nx >= POS_PAY0 && pos_nx <= POS_PAYN)
          pay_q <= {pay_q[PW-9:0], in_byte};
        if (last) open_q <= 1'b0;
        if (keep) begin
          if (!out_full) begin
            out_push    <= 1'b1;
            out_src     <= src_q;
            out_payload <= pay_q;
          end else if (ovf_count != CNT_MAX) begin
            ovf_count <= ovf_count + 1'b1;
          end
        end
      end
    end
  end
endmodule

module rx_frame_filter_chk #(
  parameter int PW = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic [7:0]       in_byte,
  input logic             out_full,
  input logic             out_push,
  input logic [7:0]       out_src,
  input logic [PW-1:0]    out_payload,
  input logic [CNT_W-1:0] ovf_count
);
  a_r2_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |=> !out_push);
  a_r2_push_after_check_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> $past(in_valid && !in_sof && in_byte[7]));
  a_r8_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> $past(!out_full));
  a_r8_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> (!out_push && $past(out_full)));
  a_r8_ovf_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> (ovf_count == $past(ovf_count) + 1'b1));
  a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_src) || !$stable(out_payload)) |-> out_push);
endmodule

bind rx_frame_filter rx_frame_filter_chk #(.PW(8*PAYLOAD_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
  .out_full(out_full), .out_push(out_push), .out_src(out_src),
  .out_payload(out_payload), .ovf_count(ovf_count)
);

// File: tb/rx_frame_filter_bench.sv
module rx_frame_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  node_addr = 8'h42;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_full = 1'b0;
  logic        out_push;
  logic [7:0]  out_src;
  logic [31:0] out_payload;
  logic [7:0]  ovf_count;

  int n_chk = 0;
  int n_bad = 0;
  int pushes = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_frame_filter u_rx_frame_filter (
    .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .in_valid(in_valid),
    .in_sof(in_sof), .in_byte(in_byte), .out_full(out_full), .out_push(out_push),
    .out_src(out_src), .out_payload(out_payload), .ovf_count(ovf_count)
  );

  always @(negedge clk) if (rst_n && out_push) pushes++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input bit sof, input logic [7:0] b);
    in_valid = 1'b1; in_sof = sof; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] src, input logic [7:0] dst,
                       input logic [31:0] pay, input bit crc_ok);
    put(1, 8'd8); put(0, src); put(0, dst);
    for (int i = 3; i >= 0; i--) put(0, pay[8*i +: 8]);
    put(0, 8'h55); put(0, {crc_ok, 7'h21});
    #1;
  endtask

  task automatic t_reset;
    chk("R1 push", out_push, 0); chk("R1 ovf", ovf_count, 0);
    chk("R1 src", out_src, 0); chk("R1 payload", out_payload, 0);
  endtask

  task automatic t_own;
    frame(8'h17, 8'h42, 32'hDEADBEEF, 1);
    chk("R2 push", out_push, 1); chk("R2 src", out_src, 8'h17);
    chk("R2 payload", out_payload, 32'hDEADBEEF);
    @(negedge clk); #1;
    chk("R2 single", out_push, 0);
    chk("R11 hold", out_payload, 32'hDEADBEEF);
  endtask

  task automatic t_bcast;
    frame(8'h09, 8'hFF, 32'h01020304, 1);
    chk("R3 push", out_push, 1); chk("R3 payload", out_payload, 32'h01020304);
    idle(2);
  endtask

  task automatic t_rejects;
    int p0 = pushes;
    frame(8'h09, 8'h43, 32'h11111111, 1); chk("R4 push", out_push, 0);
    frame(8'h09, 8'h42, 32'h22222222, 0); chk("R5 push", out_push, 0);
    frame(8'h00, 8'h42, 32'h33333333, 1); chk("R7 push", out_push, 0);
    idle(2);
    chk("R4 R5 R7 count", pushes - p0, 0);
    chk("R11 untouched", out_payload, 32'h01020304);
  endtask

  task automatic t_length;
    int p0 = pushes;
    put(1, 8'd3); put(0, 8'h05); put(0, 8'h42); put(0, 8'h80);
    put(1, 8'd10);
    for (int i = 0; i < 10; i++) put(0, 8'h80 | 8'(i));
    put(1, 8'd0);
    frame(8'h21, 8'h42, 32'hA5A5_0F0F, 1);
    chk("R6 realign push", out_push, 1);
    chk("R6 realign payload", out_payload, 32'hA5A50F0F);
    idle(2);
    chk("R6 count", pushes - p0, 1);
  endtask

  task automatic t_resync_and_gaps;
    int p0 = pushes;
    put(1, 8'd8); put(0, 8'h31); put(0, 8'h42); put(0, 8'hAA);
    put(0, 8'h12); put(0, 8'h34);
    put(1, 8'd8); put(0, 8'h32); idle(3); put(0, 8'h42);
    put(0, 8'hCA); idle(1); put(0, 8'hFE); put(0, 8'hBA); put(0, 8'hBE);
    put(0, 8'h00); idle(2); put(0, 8'h80);
    #1;
    chk("R9 R10 push", out_push, 1);
    chk("R9 src", out_src, 8'h32); chk("R10 payload", out_payload, 32'hCAFEBABE);
    put(0, 8'h80); put(0, 8'h80); idle(2);
    chk("R10 stray", pushes - p0, 1);
  endtask

  task automatic t_back_to_back;
    int p0 = pushes;
    frame(8'h44, 8'h42, 32'h0000_0001, 1);
    chk("R2 b2b first", out_src, 8'h44);
    frame(8'h45, 8'hFF, 32'h0000_0002, 1);
    chk("R2 b2b second", out_payload, 32'h2);
    idle(2);
    chk("R2 b2b count", pushes - p0, 2);
  endtask

  task automatic t_overflow;
    int p0 = pushes;
    put(1, 8'd8); put(0, 8'h50); put(0, 8'h42);
    for (int i = 0; i < 5; i++) put(0, 8'h60);
    out_full = 1'b1; put(0, 8'h80); out_full = 1'b0; #1;
    chk("R8 no push", out_push, 0); chk("R8 count", ovf_count, 1);
    frame(8'h51, 8'h42, 32'h77, 1);
    chk("R8 recover", out_push, 1);
    out_full = 1'b1;
    for (int k = 0; k < 256; k++) frame(8'h52, 8'hFF, 32'h88, 1);
    out_full = 1'b0; idle(2);
    chk("R8 saturate", ovf_count, 8'hFF);
    chk("R8 pushes", pushes - p0, 1);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; #1;
    t_reset();
    @(negedge clk);
    t_own(); t_bcast(); t_rejects(); t_length();
    t_resync_and_gaps(); t_back_to_back(); t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1; n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule